// File: doc/BRIEF.md
# Redundant Reference Selector with Divide-by-Three Enables

This block picks one of two redundant timing references, a primary and a secondary, and turns the chosen one into a lower-rate timing enable for byte-rate logic downstream. Both references reach the block as toggle streams sampled in the system clock domain. Each reference has its own activity monitor. A monitor flags loss of signal when a whole observation window of `win_len_i` system cycles passes without a transition on its input. It drops the flag only after `CLR_WINS` back-to-back windows that each show activity.

In automatic mode the selector leaves the current reference in place while that reference is healthy. It moves to the other reference only when the current one is lost and the other is not. When both are lost it stays where it is and raises an alarm. A controller write to the mode register can instead pin the selection to either reference, whatever the loss flags say.

The selected reference feeds two identical divide-by-three stages, one serving the receive side and one the transmit side. Each stage emits a one-cycle enable on every third rising edge of the selected input. Whenever the selection changes, both stages restart their count, so the phase of the enables relative to the new reference is fixed.

Top module: `ref_clk_selector`

## Requirements
- R1: After reset, `sel_o` is 0 (primary), `mode_o` is 00 (automatic), `los_o` is 00 and `alarm_o` is 0. No enable pulses appear while neither reference has a rising edge.
- R2: `los_o[0]` (primary) or `los_o[1]` (secondary) goes high once a complete window of `win_len_i` cycles passes with no transition on that input. This happens within 2*`win_len_i`+3 cycles of the input's last transition.
- R3: A raised loss flag stays high until `CLR_WINS` consecutive windows each contain at least one transition. A partial recovery shorter than one window leaves the flag set.
- R4: In automatic mode, if the selected input is lost and the other input is not, `sel_o` switches to the other input in the next cycle.
- R5: In automatic mode, `sel_o` does not change while the selected input is not lost, even after the other input recovers.
- R6: When both loss flags are set, `alarm_o` is 1 from the next cycle on and the automatic selection holds. The alarm clears once either input recovers.
- R7: A write with `cfg_wr_i` high stores `cfg_mode_i` as the mode. Code 00 means automatic, 01 forces primary and 10 forces secondary. A forced mode sets `sel_o` in the next cycle regardless of the loss flags. Code 11 is ignored and leaves the mode unchanged.
- R8: `rx_en_o` pulses for one cycle on every third rising edge of the selected input. With rising edges P cycles apart, consecutive pulses are 3*P cycles apart.
- R9: `rx_en_o` and `tx_en_o` are equal in every cycle.
- R10: On a selection change, both divide counters restart. No pulse appears in the cycle `sel_o` changes. The first pulse follows the third rising edge of the new input seen after the change.
- R11: Rising edges on the input that is not selected have no effect on the enable outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_pri_i | input | 1 | Primary reference as a toggle stream |
| ref_sec_i | input | 1 | Secondary reference as a toggle stream |
| win_len_i | input | WIN_W | Observation window length in system cycles (minimum 2) |
| cfg_wr_i | input | 1 | Mode register write strobe |
| cfg_mode_i | input | 2 | Mode write data: 00 auto, 01 force primary, 10 force secondary, 11 ignored |
| sel_o | output | 1 | Selected reference: 0 primary, 1 secondary |
| mode_o | output | 2 | Current mode register value |
| los_o | output | 2 | Loss flags, bit 0 primary, bit 1 secondary |
| alarm_o | output | 1 | Both references lost |
| rx_en_o | output | 1 | Receive-side divide-by-three enable |
| tx_en_o | output | 1 | Transmit-side divide-by-three enable |

## Verification
A stuck or miscounted window counter shows up at `los_o` within two or three window lengths. It appears either as a flag that never rises after an input stops, or as one that clears before the required number of healthy windows. A wrong selection state shows at `sel_o` one cycle after the loss flags or the mode register change, and within one enable period the pulse spacing on `rx_en_o` then follows the wrong input. A divider that keeps a stale count across a switch fires earlier than the third new edge, which the bench measures from the cycle `sel_o` changes.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    localparam int NUM_REF = 2;
    localparam int NUM_DIV = 2;

    typedef enum logic [1:0] {
        MODE_AUTO = 2'b00,
        MODE_FPRI = 2'b01,
        MODE_FSEC = 2'b10
    } mode_e;

    localparam logic [1:0] MODE_RSVD = 2'b11;

endpackage

// File: rtl/refsel_los_mon.sv
module refsel_los_mon #(
    parameter int WIN_W    = 8,
    parameter int CLR_WINS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tgl_i,
    input  logic [WIN_W-1:0] win_len_i,
    output logic             rise_o,
    output logic             los_o
);

    localparam int GOOD_W = (CLR_WINS < 2) ? 1 : $clog2(CLR_WINS);
    localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(CLR_WINS - 1);

    typedef struct packed {
        logic              prev;
        logic [WIN_W-1:0]  cnt;
        logic              seen;
        logic [GOOD_W-1:0] good;
        logic              los;
    } mon_t;

    mon_t q, d;
    logic act;
    logic [WIN_W-1:0] win_last;

    always_comb begin
        d        = q;
        d.prev   = tgl_i;
        act      = tgl_i ^ q.prev;
        win_last = (win_len_i < WIN_W'(2)) ? WIN_W'(1) : win_len_i - WIN_W'(1);
        if (q.cnt >= win_last) begin
            // window closes this cycle
            d.cnt  = '0;
            d.seen = 1'b0;
            if (!(q.seen || act)) begin
                d.los  = 1'b1;
                d.good = '0;
            end else if (q.los) begin
                if (q.good == GOOD_LAST) begin
                    d.los  = 1'b0;
                    d.good = '0;
                end else begin
                    d.good = q.good + GOOD_W'(1);
                end
            end
        end else begin
            d.cnt  = q.cnt + WIN_W'(1);
            d.seen = q.seen | act;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rise_o = tgl_i & ~q.prev;
    assign los_o  = q.los;

endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl
    import refsel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_i,
    input  logic [1:0]         cfg_mode_i,
    input  logic [NUM_REF-1:0] los_i,
    output logic               sel_o,
    output logic [1:0]         mode_o,
    output logic               alarm_o,
    output logic               restart_o
);

    typedef struct packed {
        mode_e mode;
        logic  sel;
        logic  alarm;
    } ctl_t;

    ctl_t q, d;

    always_comb begin
        d = q;
        if (cfg_wr_i && (cfg_mode_i != MODE_RSVD)) begin
            d.mode = mode_e'(cfg_mode_i);
        end
        case (q.mode)
            MODE_FPRI: d.sel = 1'b0;
            MODE_FSEC: d.sel = 1'b1;
            default: begin
                if (los_i[q.sel] && !los_i[~q.sel]) begin
                    d.sel = ~q.sel;
                end
            end
        endcase
        d.alarm   = &los_i;
        restart_o = (d.sel != q.sel);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{mode: MODE_AUTO, sel: 1'b0, alarm: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sel_o   = q.sel;
    assign mode_o  = q.mode;
    assign alarm_o = q.alarm;

endmodule

// File: rtl/refsel_div3.sv
module refsel_div3 #(
    parameter int DIV = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic rise_i,
    output logic en_o
);

    localparam int CW = (DIV < 3) ? 1 : $clog2(DIV);
    localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          en;
    } div_t;

    div_t q, d;

    always_comb begin
        d    = q;
        d.en = 1'b0;
        if (restart_i) begin
            d.cnt = '0;
        end else if (rise_i) begin
            if (q.cnt == CNT_LAST) begin
                d.cnt = '0;
                d.en  = 1'b1;
            end else begin
                d.cnt = q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign en_o = q.en;

endmodule

// File: rtl/ref_clk_selector.sv
module ref_clk_selector
    import refsel_pkg::*;
#(
    parameter int WIN_W    = 8,
    parameter int CLR_WINS = 3,
    parameter int DIV      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_pri_i,
    input  logic             ref_sec_i,
    input  logic [WIN_W-1:0] win_len_i,
    input  logic             cfg_wr_i,
    input  logic [1:0]       cfg_mode_i,
    output logic             sel_o,
    output logic [1:0]       mode_o,
    output logic [1:0]       los_o,
    output logic             alarm_o,
    output logic             rx_en_o,
    output logic             tx_en_o
);

    logic [NUM_REF-1:0] tgl;
    logic [NUM_REF-1:0] rise;
    logic [NUM_REF-1:0] los;
    logic [NUM_DIV-1:0] div_en;
    logic               restart;
    logic               sel;

    assign tgl = {ref_sec_i, ref_pri_i};

    for (genvar g = 0; g < NUM_REF; g++) begin : g_mon
        refsel_los_mon #(
            .WIN_W    (WIN_W),
            .CLR_WINS (CLR_WINS)
        ) u_mon (
            .clk       (clk),
            .rst_n     (rst_n),
            .tgl_i     (tgl[g]),
            .win_len_i (win_len_i),
            .rise_o    (rise[g]),
            .los_o     (los[g])
        );
    end

    refsel_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr_i   (cfg_wr_i),
        .cfg_mode_i (cfg_mode_i),
        .los_i      (los),
        .sel_o      (sel),
        .mode_o     (mode_o),
        .alarm_o    (alarm_o),
        .restart_o  (restart)
    );

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
        refsel_div3 #(
            .DIV (DIV)
        ) u_div (
            .clk       (clk),
            .rst_n     (rst_n),
            .restart_i (restart),
            .rise_i    (rise[sel]),
            .en_o      (div_en[g])
        );
    end

    assign sel_o   = sel;
    assign los_o   = los;
    assign rx_en_o = div_en[0];
    assign tx_en_o = div_en[1];

endmodule

// File: rtl/refsel_checker.sv
module refsel_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sel_o,
    input logic [1:0] mode_o,
    input logic [1:0] los_o,
    input logic       alarm_o,
    input logic       rx_en_o,
    input logic       tx_en_o
);

    p_force_pri_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b01) |=> (sel_o == 1'b0));

    p_force_sec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10) |=> (sel_o == 1'b1));

    p_mode_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'b11));

    p_switch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == 2'b00) && los_o[sel_o] && !los_o[~sel_o])
        |=> (sel_o != $past(sel_o)));

    p_no_revert_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == 2'b00) && !los_o[sel_o]) |=> $stable(sel_o));

    p_both_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == 2'b00) && (los_o == 2'b11)) |=> $stable(sel_o));

    p_alarm_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (los_o == 2'b11) |=> alarm_o);

    p_alarm_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (los_o != 2'b11) |=> !alarm_o);

    p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en_o |=> !rx_en_o);

    p_rx_tx_equal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en_o == tx_en_o));

    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel_o) |-> !rx_en_o);

endmodule

bind ref_clk_selector refsel_checker u_refsel_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_o   (sel_o),
    .mode_o  (mode_o),
    .los_o   (los_o),
    .alarm_o (alarm_o),
    .rx_en_o (rx_en_o),
    .tx_en_o (tx_en_o)
);

// File: tb/test_ref_clk_selector.sv
module test_ref_clk_selector;

    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 16;
    localparam int LOSS_WAIT  = 2 * WIN + 8;
    localparam int CLR_WAIT   = 6 * WIN;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_pri_i = 1'b0;
    logic       ref_sec_i = 1'b0;
    logic [7:0] win_len_i = 8'(WIN);
    logic       cfg_wr_i = 1'b0;
    logic [1:0] cfg_mode_i = 2'b00;
    logic       sel_o;
    logic [1:0] mode_o;
    logic [1:0] los_o;
    logic       alarm_o;
    logic       rx_en_o;
    logic       tx_en_o;

    int total = 0;
    int bad = 0;
    int rxtx_mismatch = 0;
    bit run_pri = 1'b0;
    bit run_sec = 1'b0;
    int half_pri = 3;
    int half_sec = 3;

    typedef struct {
        string      tag;
        logic       sel;
        logic [1:0] mode;
        logic [1:0] los;
        logic       alarm;
    } exp_t;

    exp_t sb_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    ref_clk_selector i_ref_clk_selector (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_pri_i  (ref_pri_i),
        .ref_sec_i  (ref_sec_i),
        .win_len_i  (win_len_i),
        .cfg_wr_i   (cfg_wr_i),
        .cfg_mode_i (cfg_mode_i),
        .sel_o      (sel_o),
        .mode_o     (mode_o),
        .los_o      (los_o),
        .alarm_o    (alarm_o),
        .rx_en_o    (rx_en_o),
        .tx_en_o    (tx_en_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // toggle generators, driven away from the active edge
    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            if (run_pri) begin
                c++;
                if (c >= half_pri) begin
                    ref_pri_i = ~ref_pri_i;
                    c = 0;
                end
            end
        end
    end

    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            if (run_sec) begin
                c++;
                if (c >= half_sec) begin
                    ref_sec_i = ~ref_sec_i;
                    c = 0;
                end
            end
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (rx_en_o !== tx_en_o)) rxtx_mismatch++;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                chk({e.tag, " sel"},   int'(sel_o),   int'(e.sel));
                chk({e.tag, " mode"},  int'(mode_o),  int'(e.mode));
                chk({e.tag, " los"},   int'(los_o),   int'(e.los));
                chk({e.tag, " alarm"}, int'(alarm_o), int'(e.alarm));
            end
        end
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        chk("watchdog", 1, 0);
        finish_run();
    end

    task automatic expect_st(input string tag, input logic sel, input logic [1:0] mode,
                             input logic [1:0] los, input logic alarm);
        exp_t e;
        e.tag = tag; e.sel = sel; e.mode = mode; e.los = los; e.alarm = alarm;
        sb_q.push_back(e);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_mode(input logic [1:0] m);
        @(negedge clk);
        cfg_wr_i   = 1'b1;
        cfg_mode_i = m;
        @(negedge clk);
        cfg_wr_i   = 1'b0;
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!rx_en_o && n < 400);
    endtask

    initial begin
        int d;
        int pulses;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and no pulses while idle
        cycles(2);
        expect_st("R1 reset", 1'b0, 2'b00, 2'b00, 1'b0);
        pulses = 0;
        repeat (8) begin
            @(negedge clk);
            if (rx_en_o) pulses++;
        end
        chk("R1 idle pulses", pulses, 0);

        run_pri = 1'b1;
        run_sec = 1'b1;
        cycles(100);
        expect_st("R5 both good", 1'b0, 2'b00, 2'b00, 1'b0);

        // R2 + R4: primary stops, switch to secondary
        run_pri = 1'b0;
        cycles(LOSS_WAIT);
        expect_st("R2 R4 primary lost", 1'b1, 2'b00, 2'b01, 1'b0);

        // R3: brief recovery keeps flag, full recovery clears it; R5: no revert
        run_pri = 1'b1;
        cycles(WIN);
        expect_st("R3 partial recovery", 1'b1, 2'b00, 2'b01, 1'b0);
        cycles(CLR_WAIT);
        expect_st("R3 R5 recovered no revert", 1'b1, 2'b00, 2'b00, 1'b0);

        // R4 back to primary
        run_sec = 1'b0;
        cycles(LOSS_WAIT);
        expect_st("R4 secondary lost", 1'b0, 2'b00, 2'b10, 1'b0);

        // R6: both lost
        run_pri = 1'b0;
        cycles(LOSS_WAIT);
        expect_st("R6 both lost hold", 1'b0, 2'b00, 2'b11, 1'b1);

        run_sec = 1'b1;
        cycles(CLR_WAIT);
        expect_st("R6 R4 secondary back", 1'b1, 2'b00, 2'b01, 1'b0);

        run_pri = 1'b1;
        cycles(CLR_WAIT);
        expect_st("R5 both recovered", 1'b1, 2'b00, 2'b00, 1'b0);

        // R7 force primary; R8 spacing with primary edges every 6 cycles
        write_mode(2'b01);
        cycles(2);
        expect_st("R7 force primary", 1'b0, 2'b01, 2'b00, 1'b0);
        wait_pulse(d);
        wait_pulse(d);
        chk("R8 spacing primary", d, 18);

        // R10: restart on change; R11: primary edges faster, ignored
        half_pri = 1;
        write_mode(2'b10);
        d = 0;
        while (sel_o !== 1'b1 && d < 10) begin
            @(negedge clk);
            d++;
        end
        chk("R7 force secondary sel", int'(sel_o), 1);
        wait_pulse(d);
        chk("R10 first pulse after change", int'(d >= 13 && d <= 18), 1);
        wait_pulse(d);
        chk("R11 R8 spacing secondary", d, 18);
        half_pri = 3;

        // R7: reserved code ignored
        write_mode(2'b11);
        cycles(2);
        expect_st("R7 reserved ignored", 1'b1, 2'b10, 2'b00, 1'b0);

        // R7: forced secondary holds even while lost
        run_sec = 1'b0;
        cycles(LOSS_WAIT);
        expect_st("R7 forced while lost", 1'b1, 2'b10, 2'b10, 1'b0);

        // R4: return to auto picks the good input
        write_mode(2'b00);
        cycles(3);
        expect_st("R4 auto after force", 1'b0, 2'b00, 2'b10, 1'b0);

        chk("R9 rx tx mismatches", rxtx_mismatch, 0);
        finish_run();
    end

endmodule